// File: doc/BRIEF.md
# Arithmetic Condition Evaluation Unit

This block adds or subtracts two two's-complement operands of a configurable width and, in the same step, tests a 4-bit condition code against the outcome. It produces one condition-true bit that a pipeline can use to skip the following instruction or to take a branch. Alongside that bit it delivers the arithmetic result, the carry out of the most significant bit and the signed-overflow flag.

The upper three bits of the condition code pick one of eight tests: never, zero, signed less-than, signed less-or-equal, no carry, no carry or zero, overflow and odd. The lowest bit inverts the chosen test. Both signed tests use the sign bit combined with overflow, not the sign bit alone, so they give the true signed ordering of the two operands even when the difference wraps. For subtraction, the unsigned less-or-equal test compares the operands directly. All outputs pass through an optional register stage, which is enabled by default and cleared by a synchronous reset.

Top module: `cond_eval_unit`

## Requirements
- R1: `result` equals `op_a + op_b` modulo 2^W when `is_sub` is 0, and `op_a - op_b` modulo 2^W when `is_sub` is 1.
- R2: `carry_out` is the carry out of bit W-1. For addition it is the carry of `op_a + op_b`. For subtraction it is the carry of `op_a + ~op_b + 1`, which is 1 exactly when `op_a >= op_b` as unsigned numbers.
- R3: `overflow` is 1 exactly when the mathematically exact signed sum or difference lies outside the range of a W-bit signed number.
- R4: The selector is `cond_code[3:1]` and the invert bit is `cond_code[0]`. When the invert bit is 1, `cond_true` is the complement of the selected test. Selector 0 is never true, so code 0 gives 0 and code 1 gives 1.
- R5: Selector 1 is true when the result is zero.
- R6: Selector 2 is true when result bit W-1 XOR `overflow` is 1.
- R7: Selector 3 is true when (result bit W-1 XOR `overflow`) is 1, or when the result is zero.
- R8: Selector 4 is true when `carry_out` is 0.
- R9: Selector 5 is true when `carry_out` is 0 or the result is zero. For subtraction, this test is true exactly when `op_a <= op_b` as unsigned numbers.
- R10: Selector 6 is true when `overflow` is 1.
- R11: Selector 7 is true when result bit 0 is 1.
- R12: With the default register stage, every output shows the values for the inputs that were present at the previous rising clock edge. A synchronous reset sets all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | W | First operand |
| op_b | input | W | Second operand |
| is_sub | input | 1 | 1 selects subtraction, 0 selects addition |
| cond_code | input | 4 | Selector in [3:1], invert in [0] |
| result | output | W | Sum or difference |
| carry_out | output | 1 | Carry out of the most significant bit |
| overflow | output | 1 | Signed overflow |
| cond_true | output | 1 | Evaluated condition |

## Verification
The hardest cases to reach are those where the signed tests and the plain sign bit disagree. These occur only when overflow is present, for example when the most negative value minus a positive value wraps to a non-negative result. The zero-or-borrow test on subtraction is also hard to reach, because it needs operands that are exactly equal. Random operands almost never produce these cases. The stimulus therefore crosses every pair drawn from 0, 1, -1, the most negative value and the most positive value, with both operations and all sixteen codes, before the random phase begins.

// File: rtl/cond_eval_pkg.sv
package cond_eval_pkg;

    typedef enum logic [2:0] {
        SEL_NEVER       = 3'd0,
        SEL_ZERO        = 3'd1,
        SEL_SLT         = 3'd2,
        SEL_SLE         = 3'd3,
        SEL_NOCARRY     = 3'd4,
        SEL_NOCARRY_Z   = 3'd5,
        SEL_OVF         = 3'd6,
        SEL_ODD         = 3'd7
    } sel_e;

    typedef struct packed {
        logic neg;
        logic zero;
        logic carry;
        logic ovf;
        logic odd;
    } flags_t;

    typedef struct packed {
        sel_e sel;
        logic inv;
    } code_t;

    localparam int CODE_W = 4;

    function automatic code_t split_code(input logic [CODE_W-1:0] code);
        code_t c;
        c.sel = sel_e'(code[CODE_W-1:1]);
        c.inv = code[0];
        return c;
    endfunction

endpackage

// File: rtl/cond_addsub.sv
module cond_addsub
    import cond_eval_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic         is_sub,
    output logic [W-1:0] res,
    output flags_t       flags
);
    localparam int MSB = W - 1;

    logic [W-1:0] b_eff;
    logic [W:0]   wide;
    logic         sign_diff;
    logic         res_flip;

    always_comb begin
        b_eff     = is_sub ? ~op_b : op_b;
        wide      = {1'b0, op_a} + {1'b0, b_eff} + {{W{1'b0}}, is_sub};
        res       = wide[W-1:0];
        sign_diff = op_a[MSB] ^ op_b[MSB];
        res_flip  = res[MSB] ^ op_a[MSB];
        flags.neg   = res[MSB];
        flags.zero  = (res == '0);
        flags.carry = wide[W];
        flags.ovf   = res_flip & (is_sub ? sign_diff : ~sign_diff);
        flags.odd   = res[0];
    end

endmodule

// File: rtl/cond_decode.sv
module cond_decode
    import cond_eval_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [CODE_W-1:0] cond_code,
    input  flags_t            flags,
    input  logic              is_sub,
    input  logic [W-1:0]      op_a,
    input  logic [W-1:0]      op_b,
    output logic              hit
);
    code_t c;
    logic  base;
    logic  lt_signed;
    logic  leu_direct;

    always_comb begin
        c          = split_code(cond_code);
        lt_signed  = flags.neg ^ flags.ovf;
        leu_direct = (op_a <= op_b);
        unique case (c.sel)
            SEL_NEVER:     base = 1'b0;
            SEL_ZERO:      base = flags.zero;
            SEL_SLT:       base = lt_signed;
            SEL_SLE:       base = lt_signed | flags.zero;
            SEL_NOCARRY:   base = ~flags.carry;
            SEL_NOCARRY_Z: base = is_sub ? leu_direct : (~flags.carry | flags.zero);
            SEL_OVF:       base = flags.ovf;
            SEL_ODD:       base = flags.odd;
            default:       base = 1'b0;
        endcase
        hit = base ^ c.inv;
    end

endmodule

// File: rtl/cond_outreg.sv
module cond_outreg #(
    parameter int W       = 32,
    parameter bit REG_OUT = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_res,
    input  logic         d_carry,
    input  logic         d_ovf,
    input  logic         d_hit,
    output logic [W-1:0] q_res,
    output logic         q_carry,
    output logic         q_ovf,
    output logic         q_hit
);
    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) begin
                    q_res   <= '0;
                    q_carry <= 1'b0;
                    q_ovf   <= 1'b0;
                    q_hit   <= 1'b0;
                end else begin
                    q_res   <= d_res;
                    q_carry <= d_carry;
                    q_ovf   <= d_ovf;
                    q_hit   <= d_hit;
                end
            end
        end else begin : g_pass
            assign q_res   = d_res;
            assign q_carry = d_carry;
            assign q_ovf   = d_ovf;
            assign q_hit   = d_hit;
        end
    endgenerate

endmodule

// File: rtl/cond_eval_unit.sv
module cond_eval_unit
    import cond_eval_pkg::*;
#(
    parameter int W       = 32,
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [W-1:0]      op_a,
    input  logic [W-1:0]      op_b,
    input  logic              is_sub,
    input  logic [CODE_W-1:0] cond_code,
    output logic [W-1:0]      result,
    output logic              carry_out,
    output logic              overflow,
    output logic              cond_true
);
    logic [W-1:0] sum_res;
    flags_t       sum_flags;
    logic         eval_hit;

    cond_addsub #(.W(W)) u_addsub (
        .op_a   (op_a),
        .op_b   (op_b),
        .is_sub (is_sub),
        .res    (sum_res),
        .flags  (sum_flags)
    );

    cond_decode #(.W(W)) u_decode (
        .cond_code (cond_code),
        .flags     (sum_flags),
        .is_sub    (is_sub),
        .op_a      (op_a),
        .op_b      (op_b),
        .hit       (eval_hit)
    );

    cond_outreg #(.W(W), .REG_OUT(REG_OUT)) u_outreg (
        .clk     (clk),
        .rst     (rst),
        .d_res   (sum_res),
        .d_carry (sum_flags.carry),
        .d_ovf   (sum_flags.ovf),
        .d_hit   (eval_hit),
        .q_res   (result),
        .q_carry (carry_out),
        .q_ovf   (overflow),
        .q_hit   (cond_true)
    );

endmodule

// File: rtl/cond_eval_chk.sv
module cond_eval_chk #(
    parameter int W       = 32,
    parameter bit REG_OUT = 1'b1
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] op_a,
    input logic [W-1:0] op_b,
    input logic         is_sub,
    input logic [3:0]   cond_code,
    input logic [W-1:0] s_res,
    input logic         s_ovf,
    input logic         s_hit,
    input logic [W-1:0] result,
    input logic         cond_true
);
    localparam int MSB = W - 1;

    AST_NEVER_CODE: assert property (@(posedge clk) disable iff (rst)
        (cond_code == 4'd0) |-> !s_hit);  // R4
    AST_ALWAYS_CODE: assert property (@(posedge clk) disable iff (rst)
        (cond_code == 4'd1) |-> s_hit);  // R4
    AST_ADD_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (!is_sub && op_a[MSB] == op_b[MSB] && s_res[MSB] != op_a[MSB]) |-> s_ovf);  // R3
    AST_SLT_TEST: assert property (@(posedge clk) disable iff (rst)
        (cond_code == 4'd4) |-> (s_hit == (s_res[MSB] ^ s_ovf)));  // R6
    AST_SUB_LEU: assert property (@(posedge clk) disable iff (rst)
        (is_sub && cond_code == 4'd10) |-> (s_hit == (op_a <= op_b)));  // R9
    AST_ZERO_TEST: assert property (@(posedge clk) disable iff (rst)
        (cond_code == 4'd2 && s_res == '0) |-> s_hit);  // R5

    generate
        if (REG_OUT) begin : g_lat
            AST_OUT_LATENCY: assert property (@(posedge clk) disable iff (rst)
                1'b1 |=> (result == $past(s_res) && cond_true == $past(s_hit)));  // R12
        end
    endgenerate

endmodule

bind cond_eval_unit cond_eval_chk #(.W(W), .REG_OUT(REG_OUT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .op_a      (op_a),
    .op_b      (op_b),
    .is_sub    (is_sub),
    .cond_code (cond_code),
    .s_res     (sum_res),
    .s_ovf     (sum_flags.ovf),
    .s_hit     (eval_hit),
    .result    (result),
    .cond_true (cond_true)
);

// File: tb/tb_cond_eval_unit.sv
module tb_cond_eval_unit;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic         is_sub = 1'b0;
    logic [3:0]   cond_code = '0;
    logic [W-1:0] result;
    logic         carry_out, overflow, cond_true;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;  // 50 MHz

    cond_eval_unit dut (
        .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .is_sub(is_sub),
        .cond_code(cond_code), .result(result), .carry_out(carry_out),
        .overflow(overflow), .cond_true(cond_true)
    );

    logic [W-1:0] q_res[$];
    bit           q_c[$];
    bit           q_v[$];
    bit           q_t[$];
    bit [3:0]     q_code[$];

    function automatic string sel_tag(input bit [3:0] code);
        case (code[3:1])
            3'd0: return "R4";
            3'd1: return "R5";
            3'd2: return "R6";
            3'd3: return "R7";
            3'd4: return "R8";
            3'd5: return "R9";
            3'd6: return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic push_model(input logic [W-1:0] a, input logic [W-1:0] b,
                              input bit sub, input bit [3:0] code);
        longint unsigned ua = longint'(a);
        longint unsigned ub = longint'(b);
        longint unsigned full;
        longint sa = longint'($signed(a));
        longint sb = longint'($signed(b));
        longint exact;
        logic [W-1:0] r;
        bit c, v, n, z, t;
        full  = sub ? (ua + (ub ^ 64'hFFFF_FFFF) + 1) : (ua + ub);
        r     = full[W-1:0];
        c     = full[W];
        exact = sub ? (sa - sb) : (sa + sb);
        v     = (exact > 64'sd2147483647) || (exact < -64'sd2147483648);
        n     = r[W-1];
        z     = (r == 0);
        case (code[3:1])
            3'd0: t = 0;
            3'd1: t = z;
            3'd2: t = n ^ v;
            3'd3: t = (n ^ v) | z;
            3'd4: t = !c;
            3'd5: t = sub ? (ua <= ub) : (!c | z);
            3'd6: t = v;
            default: t = r[0];
        endcase
        t = t ^ code[0];
        q_res.push_back(r); q_c.push_back(c); q_v.push_back(v);
        q_t.push_back(t); q_code.push_back(code);
    endtask

    task automatic compare_one();
        logic [W-1:0] er = q_res.pop_front();
        bit ec = q_c.pop_front();
        bit ev = q_v.pop_front();
        bit et = q_t.pop_front();
        bit [3:0] cc = q_code.pop_front();
        bit bad = 0;
        n_cmp++;
        if (result !== er) begin
            $display("FAIL R1 result act=%h exp=%h", result, er); bad = 1;
        end
        if (carry_out !== ec) begin
            $display("FAIL R2 carry_out act=%b exp=%b", carry_out, ec); bad = 1;
        end
        if (overflow !== ev) begin
            $display("FAIL R3 overflow act=%b exp=%b", overflow, ev); bad = 1;
        end
        if (cond_true !== et) begin
            $display("FAIL %s cond_true code=%0d act=%b exp=%b", sel_tag(cc), cc, cond_true, et);
            bad = 1;
        end
        if (bad) n_bad++;
    endtask

    // Drive at negedge; check the outputs registered from the previous vector (R12).
    task automatic step(input logic [W-1:0] a, input logic [W-1:0] b,
                        input bit sub, input bit [3:0] code);
        @(negedge clk);
        if (q_res.size() != 0) compare_one();
        op_a = a; op_b = b; is_sub = sub; cond_code = code;
        push_model(a, b, sub, code);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : stim
        logic [W-1:0] edges [5];
        edges[0] = 32'h0000_0000; edges[1] = 32'h0000_0001; edges[2] = 32'hFFFF_FFFF;
        edges[3] = 32'h8000_0000; edges[4] = 32'h7FFF_FFFF;
        op_a = 32'h1234_5678; op_b = 32'h0000_0001; cond_code = 4'd15;
        repeat (3) @(negedge clk);
        // R12: reset state
        n_cmp++;
        if (result !== '0 || carry_out !== 1'b0 || overflow !== 1'b0 || cond_true !== 1'b0) begin
            n_bad++;
            $display("FAIL R12 reset act=%h/%b/%b/%b exp=0/0/0/0", result, carry_out, overflow, cond_true);
        end
        rst = 1'b0;
        // Boundary cross: R1..R11, including MIN-1 wrap for signed tests and equal operands for R9
        for (int i = 0; i < 5; i++)
            for (int j = 0; j < 5; j++)
                for (int s = 0; s < 2; s++)
                    for (int k = 0; k < 16; k++)
                        step(edges[i], edges[j], s[0], k[3:0]);
        // Random phase
        for (int n = 0; n < 3000; n++) begin
            logic [W-1:0] ra = $urandom();
            logic [W-1:0] rb = (n % 7 == 0) ? ra : $urandom();
            step(ra, rb, $urandom_range(0, 1) == 1, 4'($urandom_range(0, 15)));
        end
        @(negedge clk);
        compare_one();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule